// File: doc/BRIEF.md
# Two-Level Sparse Routing Matrix

This block picks, for each input of one programmable logic block, a single signal out of a shared pool of global nets. The pool has 99 entries: a constant-low source at index 0, two clock nets at indices 1 and 2, and 96 general signals at indices 3 to 98. The pool is cut into nine fixed groups of eleven. Each of the 33 routed outputs has its own two-level tree. In the first level, one selector per group takes a 4-bit binary code. In the second level, a 9-bit one-hot field chooses which group reaches the output. Each routed output is handed to the downstream product-term array as a true and complemented pair, which gives 66 columns.

The selection is written through a serial shift chain that is clocked by the block clock and gated by a shift enable. Bits go in most-significant first. A separate update strobe moves the chain into the active configuration register, so a half-loaded chain never reaches the routing. The chain output can be shifted out to read the configuration back while the active selection stays as it is. A small controller with three states sequences this. CFG_IDLE goes to CFG_SHIFT when the shift enable is high and to CFG_COMMIT when the update strobe is high. CFG_SHIFT goes back to CFG_IDLE when the enable drops, and to CFG_COMMIT on the strobe. CFG_COMMIT copies the chain into the active register in one cycle. It then goes to CFG_COMMIT again if the strobe is still high, to CFG_SHIFT if the enable is high, and otherwise to CFG_IDLE. The strobe takes priority over the enable in every state.

Top module: `rmx_route_matrix`

## Requirements
- R1: After reset, every true output is 0, every complemented output is 1, the error flag is 0, the serial output is 0 and the controller is in CFG_IDLE.
- R2: Output o drives the pool source with index 11g+s when its one-hot field has only bit g set and group g's select code s is below 11. Index 0 is constant low, indices 1 and 2 are clock nets 0 and 1, and index 3+k is general signal k.
- R3: A group select code from 11 to 15 routes constant low through that group.
- R4: An output whose one-hot field is all zeros is driven low.
- R5: An output whose one-hot field has two or more bits set is driven low, and the error flag is high while any such output exists in the active configuration. The flag clears once a configuration without such a field is committed.
- R6: Every complemented output is always the inverse of its true output.
- R7: Output o occupies chain bits 45o to 45o+44. Bits 0 to 8 of that word are the one-hot field, where bit g selects group g. Bits 9+4g to 12+4g hold group g's select code, least-significant bit lowest. On each clock with the shift enable high the chain moves one place toward bit 1484, and the serial input enters bit 0. Shifting alone never changes the routed outputs.
- R8: An update strobe sampled at clock edge n puts the controller in CFG_COMMIT. Edge n+1 then loads the chain into the active configuration. If the strobe and the enable are high together, the strobe wins the state choice and the shift at edge n still happens.
- R9: The serial output always shows chain bit 1484. Shifting out a loaded chain returns its bits in the order they were loaded and leaves the active routing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also clocks the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| pool_clk | input | 2 | The two clock nets of the pool, treated as routable data |
| pool_sig | input | 96 | General pool signals |
| cfg_sdi | input | 1 | Serial configuration data in |
| cfg_shift_en | input | 1 | Shift enable for the configuration chain |
| cfg_update | input | 1 | Strobe that commits the chain to the active configuration |
| cfg_sdo | output | 1 | Serial readback, top bit of the chain |
| route_true | output | 33 | Routed signals toward the logic array |
| route_comp | output | 33 | Complements of the routed signals |
| err_multi | output | 1 | High while some active one-hot field has more than one bit set |

## Verification
The bench loads whole configurations that include select codes in the 11 to 15 range, empty one-hot fields, fields with two bits set, and choices of the ground and clock entries. If the decoder indexed past the end of a group, the reserved codes would route a neighbouring group's signal instead of low. If multi-hot fields were ORed together, the output would follow a mixture of groups. In that same case a stuck-low error flag would miss the fault, and a stuck-high one would fail to clear on the next commit. The bench also raises the update strobe together with the last shift bit, so a design that dropped that bit or committed one cycle early or late would show the wrong routing. Finally, the readback shifts out the whole chain while the routing is watched. A design that let shifting reach the active register, or reversed the bit order, would be caught on the routed outputs or on the serial output.

// File: rtl/rmx_pkg.sv
package rmx_pkg;

    // Controller states for configuration loading
    typedef enum logic [1:0] {
        CFG_IDLE   = 2'd0,
        CFG_SHIFT  = 2'd1,
        CFG_COMMIT = 2'd2
    } cfg_state_e;

endpackage

// File: rtl/rmx_cfg_ctrl.sv
module rmx_cfg_ctrl
    import rmx_pkg::*;
#(
    parameter int CHAIN_W = 1485
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               sdi,
    input  logic               update,
    output logic               sdo,
    output logic [CHAIN_W-1:0] chain_q,
    output logic [CHAIN_W-1:0] active_q,
    output cfg_state_e         state_q
);

    cfg_state_e state_d;
    logic       commit_now;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state choice; the update strobe wins over shifting
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_IDLE: begin
                if (update)        state_d = CFG_COMMIT;
                else if (shift_en) state_d = CFG_SHIFT;
            end
            CFG_SHIFT: begin
                if (update)         state_d = CFG_COMMIT;
                else if (!shift_en) state_d = CFG_IDLE;
            end
            CFG_COMMIT: begin
                if (update)        state_d = CFG_COMMIT;
                else if (shift_en) state_d = CFG_SHIFT;
                else               state_d = CFG_IDLE;
            end
            default: state_d = CFG_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        commit_now = 1'b0;
        unique case (state_q)
            CFG_IDLE:   commit_now = 1'b0;
            CFG_SHIFT:  commit_now = 1'b0;
            CFG_COMMIT: commit_now = 1'b1;
            default:    commit_now = 1'b0;
        endcase
    end

    // Shift chain, data enters at bit 0 and leaves at the top
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (shift_en) begin
            chain_q <= {chain_q[CHAIN_W-2:0], sdi};
        end
    end

    // Active configuration, written only in the commit state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (commit_now) begin
            active_q <= chain_q;
        end
    end

    assign sdo = chain_q[CHAIN_W-1];

endmodule

// File: rtl/rmx_grp_sel.sv
module rmx_grp_sel #(
    parameter int GRP_W = 11,
    parameter int SEL_W = 4
) (
    input  logic [GRP_W-1:0] grp_src,
    input  logic [SEL_W-1:0] sel,
    output logic             out_bit
);

    // Codes at or above GRP_W match no entry and leave the output low
    always_comb begin
        out_bit = 1'b0;
        for (int i = 0; i < GRP_W; i++) begin
            if (sel == SEL_W'(i)) out_bit = grp_src[i];
        end
    end

endmodule

// File: rtl/rmx_out_sel.sv
module rmx_out_sel #(
    parameter int N_GRP = 9
) (
    input  logic [N_GRP-1:0] stage1,
    input  logic [N_GRP-1:0] onehot,
    output logic             out_bit,
    output logic             multi
);

    // More than one bit set when clearing the lowest set bit leaves any bit
    always_comb begin
        multi   = |(onehot & (onehot - N_GRP'(1)));
        out_bit = multi ? 1'b0 : |(stage1 & onehot);
    end

endmodule

// File: rtl/rmx_route_matrix.sv
module rmx_route_matrix
    import rmx_pkg::*;
#(
    parameter int N_CLK = 2,
    parameter int N_GEN = 96,
    parameter int N_GRP = 9,
    parameter int GRP_W = 11,
    parameter int N_OUT = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CLK-1:0] pool_clk,
    input  logic [N_GEN-1:0] pool_sig,
    input  logic             cfg_sdi,
    input  logic             cfg_shift_en,
    input  logic             cfg_update,
    output logic             cfg_sdo,
    output logic [N_OUT-1:0] route_true,
    output logic [N_OUT-1:0] route_comp,
    output logic             err_multi
);

    localparam int N_SRC   = 1 + N_CLK + N_GEN;
    localparam int SEL_W   = $clog2(GRP_W);
    localparam int WORD_W  = N_GRP + N_GRP * SEL_W;
    localparam int CHAIN_W = N_OUT * WORD_W;

    logic [N_SRC-1:0]   pool;
    logic [CHAIN_W-1:0] chain_w;
    logic [CHAIN_W-1:0] active_w;
    cfg_state_e         state_w;
    logic [N_OUT-1:0]   multi_vec;

    // Pool order: ground, clock nets, general signals
    assign pool = {pool_sig, pool_clk, 1'b0};

    rmx_cfg_ctrl #(
        .CHAIN_W (CHAIN_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift_en),
        .sdi      (cfg_sdi),
        .update   (cfg_update),
        .sdo      (cfg_sdo),
        .chain_q  (chain_w),
        .active_q (active_w),
        .state_q  (state_w)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [WORD_W-1:0] word;
        logic [N_GRP-1:0]  stage1;

        assign word = active_w[o*WORD_W +: WORD_W];

        for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            rmx_grp_sel #(
                .GRP_W (GRP_W),
                .SEL_W (SEL_W)
            ) u_grp (
                .grp_src (pool[g*GRP_W +: GRP_W]),
                .sel     (word[N_GRP + g*SEL_W +: SEL_W]),
                .out_bit (stage1[g])
            );
        end

        rmx_out_sel #(
            .N_GRP (N_GRP)
        ) u_sel (
            .stage1  (stage1),
            .onehot  (word[N_GRP-1:0]),
            .out_bit (route_true[o]),
            .multi   (multi_vec[o])
        );
    end

    assign route_comp = ~route_true;
    assign err_multi  = |multi_vec;

endmodule

// File: rtl/rmx_route_matrix_chk.sv
module rmx_route_matrix_chk
    import rmx_pkg::*;
#(
    parameter int N_OUT   = 33,
    parameter int N_GRP   = 9,
    parameter int WORD_W  = 45,
    parameter int CHAIN_W = 1485
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_shift_en,
    input logic               cfg_update,
    input logic               cfg_sdo,
    input logic [N_OUT-1:0]   route_true,
    input logic               err_multi,
    input logic [CHAIN_W-1:0] chain,
    input logic [CHAIN_W-1:0] active,
    input cfg_state_e         state
);

    // R8: a sampled strobe always leads to the commit state
    assert_update_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_update |=> state == CFG_COMMIT);

    // R8: the commit state loads the chain as it stood
    assert_commit_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state == CFG_COMMIT |=> active == $past(chain));

    // R7: outside the commit state the active configuration holds
    assert_active_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state != CFG_COMMIT |=> $stable(active));

    // R9: a shift brings the next chain bit to the serial output
    assert_sdo_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift_en |=> cfg_sdo == $past(chain[CHAIN_W-2]));

    for (genvar o = 0; o < N_OUT; o++) begin : g_chk
        logic [N_GRP-1:0] oh;
        assign oh = active[o*WORD_W +: N_GRP];

        // R4: empty one-hot field keeps the output low
        assert_empty_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            oh == '0 |-> !route_true[o]);

        // R5: multi-hot field keeps the output low and flags the error
        assert_multi_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(oh) > 1 |-> (!route_true[o] && err_multi));
    end

endmodule

bind rmx_route_matrix rmx_route_matrix_chk #(
    .N_OUT   (N_OUT),
    .N_GRP   (N_GRP),
    .WORD_W  (WORD_W),
    .CHAIN_W (CHAIN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_shift_en (cfg_shift_en),
    .cfg_update   (cfg_update),
    .cfg_sdo      (cfg_sdo),
    .route_true   (route_true),
    .err_multi    (err_multi),
    .chain        (chain_w),
    .active       (active_w),
    .state        (state_w)
);

// File: tb/rmx_route_matrix_test.sv
module rmx_route_matrix_test;

    localparam int N_CLK   = 2;
    localparam int N_GEN   = 96;
    localparam int N_GRP   = 9;
    localparam int GRP_W   = 11;
    localparam int N_OUT   = 33;
    localparam int SEL_W   = 4;
    localparam int WORD_W  = N_GRP + N_GRP * SEL_W;
    localparam int CHAIN_W = N_OUT * WORD_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_CLK-1:0] pool_clk = '0;
    logic [N_GEN-1:0] pool_sig = '0;
    logic             cfg_sdi = 1'b0;
    logic             cfg_shift_en = 1'b0;
    logic             cfg_update = 1'b0;
    logic             cfg_sdo;
    logic [N_OUT-1:0] route_true;
    logic [N_OUT-1:0] route_comp;
    logic             err_multi;

    always #2 clk = ~clk;

    rmx_route_matrix uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pool_clk     (pool_clk),
        .pool_sig     (pool_sig),
        .cfg_sdi      (cfg_sdi),
        .cfg_shift_en (cfg_shift_en),
        .cfg_update   (cfg_update),
        .cfg_sdo      (cfg_sdo),
        .route_true   (route_true),
        .route_comp   (route_comp),
        .err_multi    (err_multi)
    );

    // Reference state
    bit    m_chain  [CHAIN_W];
    bit    m_active [CHAIN_W];
    bit    m_pend;
    bit    img      [CHAIN_W];
    int    checks = 0;
    int    errors = 0;
    string phase = "R1";

    task automatic chk(bit ok, string req, string what, logic [N_OUT-1:0] act, logic [N_OUT-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit src_val(int idx);
        if (idx == 0) return 1'b0;
        if (idx <= N_CLK) return pool_clk[idx-1];
        return pool_sig[idx-1-N_CLK];
    endfunction

    function automatic bit out_val(int o, output bit bad);
        int base = o * WORD_W;
        int cnt = 0;
        int grp = 0;
        int sel = 0;
        for (int g = 0; g < N_GRP; g++) begin
            if (m_active[base+g]) begin
                cnt++;
                grp = g;
            end
        end
        bad = (cnt > 1);
        if (cnt != 1) return 1'b0;
        for (int b = 0; b < SEL_W; b++) begin
            if (m_active[base + N_GRP + grp*SEL_W + b]) sel += (1 << b);
        end
        if (sel >= GRP_W) return 1'b0;
        return src_val(grp * GRP_W + sel);
    endfunction

    // Model update on each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CHAIN_W; i++) begin
                m_chain[i]  = 1'b0;
                m_active[i] = 1'b0;
            end
            m_pend = 1'b0;
        end else begin
            if (m_pend) m_active = m_chain;
            if (cfg_shift_en) begin
                for (int i = CHAIN_W-1; i > 0; i--) m_chain[i] = m_chain[i-1];
                m_chain[0] = cfg_sdi;
            end
            m_pend = cfg_update;
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        logic [N_OUT-1:0] exp_vec;
        bit               exp_err;
        bit               bad;
        exp_err = 1'b0;
        for (int o = 0; o < N_OUT; o++) begin
            exp_vec[o] = out_val(o, bad);
            if (bad) exp_err = 1'b1;
        end
        chk(route_true === exp_vec, phase, "route_true", route_true, exp_vec);
        chk(route_comp === ~exp_vec, "R6", "route_comp", route_comp, ~exp_vec);
        chk(err_multi === exp_err, "R5", "err_multi", N_OUT'(err_multi), N_OUT'(exp_err));
        chk(cfg_sdo === m_chain[CHAIN_W-1], "R9", "cfg_sdo", N_OUT'(cfg_sdo), N_OUT'(m_chain[CHAIN_W-1]));
    end

    task automatic clear_img();
        for (int i = 0; i < CHAIN_W; i++) img[i] = 1'b0;
    endtask

    task automatic set_oh(int o, int mask);
        for (int b = 0; b < N_GRP; b++) img[o*WORD_W + b] = mask[b];
    endtask

    task automatic set_sel(int o, int g, int val);
        for (int b = 0; b < SEL_W; b++) img[o*WORD_W + N_GRP + g*SEL_W + b] = val[b];
    endtask

    task automatic load_img(bit upd_on_last);
        for (int i = CHAIN_W-1; i >= 0; i--) begin
            cfg_sdi      = img[i];
            cfg_shift_en = 1'b1;
            cfg_update   = upd_on_last && (i == 0);
            @(posedge clk); #1;
        end
        cfg_shift_en = 1'b0;
        cfg_update   = 1'b0;
        cfg_sdi      = 1'b0;
    endtask

    task automatic pulse_update();
        cfg_update = 1'b1;
        @(posedge clk); #1;
        cfg_update = 1'b0;
        repeat (2) begin @(posedge clk); #1; end
    endtask

    task automatic vary_pool(int n);
        for (int p = 0; p < n; p++) begin
            case (p % 4)
                0: pool_sig = '1;
                1: pool_sig = '0;
                2: pool_sig = {N_GEN{1'b0}} | (N_GEN'(1) << (p % N_GEN));
                default: pool_sig = {$urandom, $urandom, $urandom};
            endcase
            pool_clk = N_CLK'(p);
            @(posedge clk); #1;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(route_true === '0, "R1", "route_true", route_true, '0);
        chk(route_comp === '1, "R1", "route_comp", route_comp, '1);
        chk(err_multi === 1'b0, "R1", "err_multi", N_OUT'(err_multi), '0);
        chk(cfg_sdo === 1'b0, "R1", "cfg_sdo", N_OUT'(cfg_sdo), '0);
        @(posedge clk); #1;

        // Config A: one group per output, all selects in range
        clear_img();
        for (int o = 0; o < N_OUT; o++) begin
            set_oh(o, 1 << (o % N_GRP));
            for (int g = 0; g < N_GRP; g++) set_sel(o, g, (o + 3*g) % GRP_W);
        end
        pool_sig = {$urandom, $urandom, $urandom};
        pool_clk = 2'b11;
        phase = "R7";
        load_img(1'b0);
        repeat (3) begin @(posedge clk); #1; end
        phase = "R8";
        pulse_update();
        phase = "R2";
        vary_pool(40);

        // Config B: reserved codes, empty, multi-hot, clock and ground picks
        clear_img();
        for (int o = 0; o < N_OUT; o++) begin
            for (int g = 0; g < N_GRP; g++) set_sel(o, g, (o + g) % GRP_W);
            case (o % 6)
                0: set_oh(o, 1 << ((o / 6) % N_GRP));
                1: begin set_oh(o, 1 << (o % N_GRP)); set_sel(o, o % N_GRP, GRP_W + (o % 5)); end
                2: set_oh(o, 0);
                3: set_oh(o, 3 << (o % 7));
                4: begin set_oh(o, 1); set_sel(o, 0, 1 + (o % 2)); end
                default: begin set_oh(o, 1); set_sel(o, 0, 0); end
            endcase
        end
        phase = "R7";
        load_img(1'b1);
        phase = "R8";
        repeat (3) begin @(posedge clk); #1; end
        phase = "R3 R4 R5";
        vary_pool(40);

        // R9: read the chain back; routing must not move
        phase = "R9";
        for (int i = 0; i < CHAIN_W; i++) begin
            cfg_shift_en = 1'b1;
            cfg_sdi      = 1'b0;
            if (i % 97 == 0) pool_sig = {$urandom, $urandom, $urandom};
            @(posedge clk); #1;
        end
        cfg_shift_en = 1'b0;
        vary_pool(8);

        // Commit the cleared chain: all low, flag clears
        phase = "R4 R5";
        pulse_update();
        vary_pool(12);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule